// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block resolves a conditional, PC-relative branch in a processor whose program counter counts half-bytes. Each cycle it takes the decoded branch fields and the four status flags (overflow V, negative N, carry C, zero Z), then decides whether the branch is taken. In the same combinational pass it forms the address of the next instruction and the number of execution cycles. A program counter register inside the block loads that address whenever the execute strobe is high.

The displacement arrives as an 11-bit raw field. A two-bit form selector picks a 4-, 7- or 11-bit signed displacement, and each form has its own instruction length of 3, 4 or 5 half-bytes. A separate half-byte bit H is added to the taken target. Fetch, decode and the ALU that produces the flags live outside this block.

Top module: `bt_branch_unit`

## Requirements
- R1: Condition code 0 (equal) is true when Z=1, and code 1 (not equal) is true when Z=0.
- R2: Code 2 (signed greater-or-equal) is true when V xor N is 0, and code 3 (signed less-than) is true when V xor N is 1.
- R3: Code 4 (signed less-or-equal) is true when (V xor N) or Z is 1, and code 5 (signed greater-than) is true when that term is 0.
- R4: Code 6 (carry clear) is true when C=0, and code 7 (carry set) is true when C=1.
- R5: A taken branch gives next_pc = pc + length + sign-extended displacement + H. The form selects the displacement and length: form 0 uses disp_raw[3:0] with length 3, form 1 uses disp_raw[6:0] with length 4, form 2 uses disp_raw[10:0] with length 5, and form 3 behaves as form 2. Raw bits above the selected field have no effect.
- R6: A branch that is not taken gives next_pc = pc + length, with H and the displacement ignored.
- R7: Form 0 is legal only with codes 0 and 1. With any other code the branch is not taken.
- R8: Codes 8 to 15 are unused. They never branch, whatever the flags are.
- R9: cycles is 1 when the branch is not taken and 3 + wait_cyc when it is taken.
- R10: All PC arithmetic wraps modulo 2^PC_W.
- R11: When rst_n goes low, pc takes RESET_VEC at once. After rst_n rises, pc stays at RESET_VEC until the internal reset has cleared through a synchronizer of SYNC_STAGES flops.
- R12: On a rising clock edge with exec_en high, pc loads next_pc. With exec_en low, pc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; pc loads next_pc when high |
| cond_code | input | 4 | Branch condition code |
| disp_form | input | 2 | Displacement form selector |
| disp_raw | input | 11 | Raw displacement field |
| half_bit | input | 1 | Half-byte bit H added to the taken target |
| flag_v | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| wait_cyc | input | WAIT_W | Extra cycles for a taken branch |
| pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Address of the next instruction |
| taken | output | 1 | Branch taken |
| cycles | output | WAIT_W+2 | Execution cycles of the instruction |

## Verification
The bench uses the most negative and most positive displacement in each form. A sign extension taken from the wrong bit would turn these into large positive jumps. It also puts ones in the raw bits above a short field and checks that they are ignored, which catches a design that reads the full 11 bits.

Each condition code is tried with flag patterns on both sides of its threshold, so a swapped code or a missing Z term in the signed-compare conditions shows up as a wrong taken flag. Form 0 is paired with a non-equality code, and unused codes are driven with every flag set; a permissive decoder would branch in both cases.

The reset vector sits just below the top of the address space, so a forward branch has to wrap, and an adder that carries past PC_W gives the wrong address. The bench also asserts reset in the middle of a run and drives the execute strobe inside the synchronizer window. A design that released reset asynchronously would load the PC too early.

// File: rtl/bt_pkg.sv
package bt_pkg;

  localparam int DISP_W = 11;
  localparam int LEN_W  = 3;

  typedef enum logic [1:0] {
    FORM_D4   = 2'd0,
    FORM_D7   = 2'd1,
    FORM_D11  = 2'd2,
    FORM_D11B = 2'd3
  } disp_form_e;

  localparam logic [3:0] CND_EQ = 4'd0;
  localparam logic [3:0] CND_NE = 4'd1;
  localparam logic [3:0] CND_GE = 4'd2;
  localparam logic [3:0] CND_LT = 4'd3;
  localparam logic [3:0] CND_LE = 4'd4;
  localparam logic [3:0] CND_GT = 4'd5;
  localparam logic [3:0] CND_CC = 4'd6;
  localparam logic [3:0] CND_CS = 4'd7;

  localparam logic [LEN_W-1:0] LEN_D4  = 3'd3;
  localparam logic [LEN_W-1:0] LEN_D7  = 3'd4;
  localparam logic [LEN_W-1:0] LEN_D11 = 3'd5;

endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
      end
      assign srst_n = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
  import bt_pkg::*;
(
  input  logic [3:0]  cond_code,
  input  disp_form_e  form,
  input  logic        flag_v,
  input  logic        flag_n,
  input  logic        flag_c,
  input  logic        flag_z,
  output logic        cond_met
);

  logic sgn_lt;
  logic raw_met;
  logic form_ok;

  always_comb begin
    sgn_lt = flag_v ^ flag_n;
    case (cond_code)
      CND_EQ:  raw_met = flag_z;
      CND_NE:  raw_met = ~flag_z;
      CND_GE:  raw_met = ~sgn_lt;
      CND_LT:  raw_met = sgn_lt;
      CND_LE:  raw_met = sgn_lt | flag_z;
      CND_GT:  raw_met = ~(sgn_lt | flag_z);
      CND_CC:  raw_met = ~flag_c;
      CND_CS:  raw_met = flag_c;
      default: raw_met = 1'b0;
    endcase
    form_ok  = (form != FORM_D4) || (cond_code == CND_EQ) || (cond_code == CND_NE);
    cond_met = raw_met & form_ok;
  end

endmodule

// File: rtl/bt_disp_ext.sv
module bt_disp_ext
  import bt_pkg::*;
#(
  parameter int PC_W = 20
) (
  input  disp_form_e              form,
  input  logic [DISP_W-1:0]       disp_raw,
  output logic [PC_W-1:0]         disp_sx,
  output logic [LEN_W-1:0]        length
);

  localparam int EXT4  = PC_W - 4;
  localparam int EXT7  = PC_W - 7;
  localparam int EXT11 = PC_W - DISP_W;

  always_comb begin
    case (form)
      FORM_D4: begin
        disp_sx = {{EXT4{disp_raw[3]}}, disp_raw[3:0]};
        length  = LEN_D4;
      end
      FORM_D7: begin
        disp_sx = {{EXT7{disp_raw[6]}}, disp_raw[6:0]};
        length  = LEN_D7;
      end
      default: begin
        disp_sx = {{EXT11{disp_raw[DISP_W-1]}}, disp_raw};
        length  = LEN_D11;
      end
    endcase
  end

endmodule

// File: rtl/bt_pc_reg.sv
module bt_pc_reg #(
  parameter int              PC_W      = 20,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PC_W-1:0] pc_d,
  output logic [PC_W-1:0] pc_q
);

  logic [PC_W-1:0] pc_nxt;

  always_comb pc_nxt = load_en ? pc_d : pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_VEC;
    else        pc_q <= pc_nxt;
  end

endmodule

// File: rtl/bt_branch_unit.sv
module bt_branch_unit
  import bt_pkg::*;
#(
  parameter int              PC_W        = 20,
  parameter logic [PC_W-1:0] RESET_VEC   = '0,
  parameter int              WAIT_W      = 4,
  parameter int              SYNC_STAGES = 2,
  localparam int             CYC_W       = WAIT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        cond_code,
  input  logic [1:0]        disp_form,
  input  logic [DISP_W-1:0] disp_raw,
  input  logic              half_bit,
  input  logic              flag_v,
  input  logic              flag_n,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic [WAIT_W-1:0] wait_cyc,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [CYC_W-1:0]  cycles
);

  disp_form_e       form;
  logic             rst_s_n;
  logic             cond_met;
  logic [PC_W-1:0]  disp_sx;
  logic [LEN_W-1:0] length;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  jmp_ofs;

  assign form = disp_form_e'(disp_form);

  bt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  bt_cond_eval u_cond (
    .cond_code (cond_code),
    .form      (form),
    .flag_v    (flag_v),
    .flag_n    (flag_n),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .cond_met  (cond_met)
  );

  bt_disp_ext #(.PC_W(PC_W)) u_disp (
    .form     (form),
    .disp_raw (disp_raw),
    .disp_sx  (disp_sx),
    .length   (length)
  );

  always_comb begin
    seq_pc  = pc_q + PC_W'(length);
    jmp_ofs = disp_sx + PC_W'(half_bit);
    taken   = cond_met;
    next_pc = cond_met ? (seq_pc + jmp_ofs) : seq_pc;
    cycles  = cond_met ? (CYC_W'(3) + CYC_W'(wait_cyc)) : CYC_W'(1);
  end

  bt_pc_reg #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_en (exec_en),
    .pc_d    (next_pc),
    .pc_q    (pc_q)
  );

  assign pc = pc_q;

endmodule

// File: rtl/bt_branch_unit_chk.sv
module bt_branch_unit_chk #(
  parameter int PC_W   = 20,
  parameter int WAIT_W = 4,
  localparam int CYC_W = WAIT_W + 2
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              exec_en,
  input logic [3:0]        cond_code,
  input logic [1:0]        disp_form,
  input logic              taken,
  input logic [WAIT_W-1:0] wait_cyc,
  input logic [CYC_W-1:0]  cycles,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   next_pc
);

  logic [PC_W-1:0] step;
  always_comb step = (disp_form == 2'd0) ? PC_W'(3) :
                     (disp_form == 2'd1) ? PC_W'(4) : PC_W'(5);

  a_r9_taken_cycles: assert property (@(posedge clk) disable iff (!rst_s_n)
    taken |-> cycles == CYC_W'(3) + CYC_W'(wait_cyc));

  a_r9_idle_cycles: assert property (@(posedge clk) disable iff (!rst_s_n)
    !taken |-> cycles == CYC_W'(1));

  a_r8_unused_never: assert property (@(posedge clk) disable iff (!rst_s_n)
    cond_code[3] |-> !taken);

  a_r7_short_form: assert property (@(posedge clk) disable iff (!rst_s_n)
    (disp_form == 2'd0 && cond_code[3:1] != 3'd0) |-> !taken);

  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    !taken |-> next_pc == pc + step);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !exec_en |=> $stable(pc));

  a_r12_load: assert property (@(posedge clk) disable iff (!rst_s_n)
    exec_en |=> pc == $past(next_pc));

endmodule

bind bt_branch_unit bt_branch_unit_chk #(.PC_W(PC_W), .WAIT_W(WAIT_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .exec_en   (exec_en),
  .cond_code (cond_code),
  .disp_form (disp_form),
  .taken     (taken),
  .wait_cyc  (wait_cyc),
  .cycles    (cycles),
  .pc        (pc),
  .next_pc   (next_pc)
);

// File: tb/bt_branch_unit_test.sv
module bt_branch_unit_test;

  localparam int              CLK_PERIOD = 10;
  localparam int              PC_W       = 20;
  localparam int              WAIT_W     = 4;
  localparam logic [PC_W-1:0] RST_VEC    = 20'hFFFF0;
  localparam int              NVEC       = 22;

  // fields: cond[38:35] form[34:33] disp[32:22] h[21] vncz[20:17] taken[16] delta[15:0]
  localparam logic [38:0] VECS [NVEC] = '{
    {4'd0, 2'd0, 11'h7F5, 1'b0, 4'b0001, 1'b1, 16'sd8},
    {4'd0, 2'd0, 11'h00F, 1'b1, 4'b0001, 1'b1, 16'sd3},
    {4'd0, 2'd0, 11'h005, 1'b0, 4'b0000, 1'b0, 16'sd3},
    {4'd1, 2'd1, 11'h7C0, 1'b0, 4'b0000, 1'b1, -16'sd60},
    {4'd1, 2'd1, 11'h040, 1'b0, 4'b0001, 1'b0, 16'sd4},
    {4'd2, 2'd1, 11'h03F, 1'b1, 4'b1100, 1'b1, 16'sd68},
    {4'd3, 2'd1, 11'h001, 1'b0, 4'b1000, 1'b1, 16'sd5},
    {4'd3, 2'd2, 11'h001, 1'b0, 4'b0000, 1'b0, 16'sd5},
    {4'd4, 2'd2, 11'h400, 1'b0, 4'b0001, 1'b1, -16'sd1019},
    {4'd4, 2'd2, 11'h3FF, 1'b1, 4'b0100, 1'b1, 16'sd1029},
    {4'd5, 2'd2, 11'h010, 1'b0, 4'b0000, 1'b1, 16'sd21},
    {4'd5, 2'd1, 11'h010, 1'b0, 4'b0001, 1'b0, 16'sd4},
    {4'd6, 2'd1, 11'h07E, 1'b1, 4'b0000, 1'b1, 16'sd3},
    {4'd7, 2'd1, 11'h07E, 1'b1, 4'b0000, 1'b0, 16'sd4},
    {4'd7, 2'd3, 11'h7FF, 1'b0, 4'b0010, 1'b1, 16'sd4},
    {4'd2, 2'd0, 11'h005, 1'b0, 4'b0000, 1'b0, 16'sd3},
    {4'd9, 2'd2, 11'h005, 1'b1, 4'b1111, 1'b0, 16'sd5},
    {4'd15, 2'd1, 11'h005, 1'b0, 4'b0001, 1'b0, 16'sd4},
    {4'd5, 2'd2, 11'h010, 1'b0, 4'b1000, 1'b0, 16'sd5},
    {4'd6, 2'd2, 11'h010, 1'b0, 4'b0010, 1'b0, 16'sd5},
    {4'd2, 2'd2, 11'h010, 1'b0, 4'b0100, 1'b0, 16'sd5},
    {4'd1, 2'd0, 11'h008, 1'b1, 4'b0000, 1'b1, -16'sd4}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              exec_en;
  logic [3:0]        cond_code;
  logic [1:0]        disp_form;
  logic [10:0]       disp_raw;
  logic              half_bit;
  logic              flag_v, flag_n, flag_c, flag_z;
  logic [WAIT_W-1:0] wait_cyc;
  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   next_pc;
  logic              taken;
  logic [WAIT_W+1:0] cycles;

  int checks   = 0;
  int failures = 0;
  logic [PC_W-1:0] pc_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_branch_unit #(.PC_W(PC_W), .RESET_VEC(RST_VEC), .WAIT_W(WAIT_W)) uut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .cond_code(cond_code),
    .disp_form(disp_form), .disp_raw(disp_raw), .half_bit(half_bit),
    .flag_v(flag_v), .flag_n(flag_n), .flag_c(flag_c), .flag_z(flag_z),
    .wait_cyc(wait_cyc), .pc(pc), .next_pc(next_pc), .taken(taken), .cycles(cycles)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [38:0] v, input logic [WAIT_W-1:0] w);
    cond_code = v[38:35];
    disp_form = v[34:33];
    disp_raw  = v[32:22];
    half_bit  = v[21];
    {flag_v, flag_n, flag_c, flag_z} = v[20:17];
    wait_cyc  = w;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    exec_en = 1'b0;
    apply(VECS[0], '0);
    repeat (3) @(negedge clk);
    check("R11 pc during reset", 32'(pc), 32'(RST_VEC));
    rst_n = 1'b1;
    exec_en = 1'b1;
    @(negedge clk);
    check("R11 pc held in sync window", 32'(pc), 32'(RST_VEC));
    exec_en = 1'b0;
    repeat (2) @(negedge clk);
    pc_model = RST_VEC;

    // R10: forward branch wraps past the top of the address space
    apply(VECS[9], 4'd2);
    #1;
    check("R10 wrapped next_pc", 32'(next_pc), 32'(20'h003F5));
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    check("R10 R12 pc after wrap", 32'(pc), 32'(20'h003F5));
    pc_model = 20'h003F5;

    // R12: no load without the strobe
    apply(VECS[0], '0);
    @(negedge clk);
    check("R12 pc holds with exec_en low", 32'(pc), 32'(pc_model));

    for (int i = 0; i < NVEC; i++) begin
      logic [PC_W-1:0]   exp_pc;
      logic [WAIT_W+1:0] exp_cyc;
      logic              exp_tk;
      logic [WAIT_W-1:0] w;
      w = WAIT_W'(i % 4 * 3);
      apply(VECS[i], w);
      exp_tk  = VECS[i][16];
      exp_pc  = pc_model + {{(PC_W-16){VECS[i][15]}}, VECS[i][15:0]};
      exp_cyc = exp_tk ? (6'd3 + 6'(w)) : 6'd1;
      #1;
      check($sformatf("R1 R2 R3 R4 R7 R8 taken vec%0d", i), 32'(taken), 32'(exp_tk));
      check($sformatf("R5 R6 next_pc vec%0d", i), 32'(next_pc), 32'(exp_pc));
      check($sformatf("R9 cycles vec%0d", i), 32'(cycles), 32'(exp_cyc));
      exec_en = 1'b1;
      @(negedge clk);
      exec_en = 1'b0;
      check($sformatf("R12 pc load vec%0d", i), 32'(pc), 32'(exp_pc));
      pc_model = exp_pc;
    end

    // R11: asynchronous reset mid-run, then synchronized release
    #2;
    rst_n = 1'b0;
    #1;
    check("R11 async reset", 32'(pc), 32'(RST_VEC));
    @(negedge clk);
    rst_n = 1'b1;
    apply(VECS[0], '0);
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    check("R11 no load before release", 32'(pc), 32'(RST_VEC));

    finish_run();
  end

endmodule